// File: doc/BRIEF.md
# Trap Entry and Vector Redirect Unit

This unit sits beside the fetch stage of a 32-bit processor pipeline and owns the program counter together with the special registers that record why control left normal flow. Each cycle the pipeline offers it the next sequential PC. It also offers the address of the instruction being retired, a flag telling whether that instruction occupies a delay slot, and the target of the branch that owns the slot. Alongside these come up to four event requests: hardware exception, break, external interrupt and user trap.

When no event is taken, the PC simply follows the pipeline's next PC. When an event is taken, the unit redirects the PC to a fixed per-event vector. It emits a one-cycle write of a return address into a dedicated link register of the general register file, and it updates the machine status, exception status, exception address, floating-point status and branch target registers. If several events arrive together, a fixed ranking picks exactly one of them. Enable and in-progress bits in the status register decide whether an exception or an interrupt request may be accepted at all.

Top module: `trap_vector_unit`

## Requirements
- R1: While reset is asserted and after its release, before any clock edge: pc is 0x00000000, msr holds parameter RESET_MSR (default 0x00000102), and esr, ear, fsr and btr are 0 with rfWe low.
- R2: An accepted hardware exception sets pc to 0x00000020 on the next edge, clears msr bit 8 (exception enable) and sets msr bit 9 (exception in progress).
- R3: An accepted exception outside a delay slot writes curPc+4 to register 17 (rfWe high for one cycle), clears esr bit 12 and leaves btr unchanged.
- R4: An accepted exception inside a delay slot sets esr bit 12, loads btr with branchTarget and makes no register-file write.
- R5: An accepted exception loads esr[4:0] with excCause, ear with excAddr and fsr with excFsr.
- R6: An exception request while msr bit 8 is clear is ignored: pc takes nextPc and esr, ear, fsr and msr keep their values.
- R7: A break writes curPc to register 16, sets pc to 0x00000018 and sets msr bit 3 (break in progress).
- R8: An interrupt that is accepted writes curPc to register 14, sets pc to 0x00000010 and clears msr bit 1 (interrupt enable).
- R9: An interrupt is accepted only while msr bit 1 is set and msr bits 3 and 9 are both clear; otherwise pc takes nextPc and no register write occurs.
- R10: A user trap writes curPc to the register numbered by usrReg, sets pc to 0x00000008 and leaves msr unchanged.
- R11: Among requests present in the same cycle exactly one is taken, ranked accepted exception, break, accepted interrupt, user trap; a request that is not accepted does not block a lower-ranked one.
- R12: With no event taken, pc loads nextPc and rfWe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| nextPc | input | XLEN | Sequential next PC from the pipeline |
| curPc | input | XLEN | Address of the instruction at which the event is taken |
| inDelaySlot | input | 1 | That instruction sits in a branch delay slot |
| branchTarget | input | XLEN | Target of the branch owning the delay slot |
| excReq | input | 1 | Hardware exception request |
| excCause | input | CAUSE_W | Exception cause code |
| excAddr | input | XLEN | Exception address value |
| excFsr | input | XLEN | Floating-point status value for the exception |
| brkReq | input | 1 | Break request (hardware or software) |
| irqReq | input | 1 | External interrupt request |
| usrReq | input | 1 | User trap request |
| usrReg | input | RIDX_W | Link register chosen for the user trap |
| pc | output | XLEN | Program counter |
| msr | output | XLEN | Machine status register |
| esr | output | XLEN | Exception status register |
| ear | output | XLEN | Exception address register |
| fsr | output | XLEN | Floating-point status register |
| btr | output | XLEN | Branch target register |
| rfWe | output | 1 | Link register write strobe |
| rfAddr | output | RIDX_W | Link register index |
| rfData | output | XLEN | Return address written |

## Verification
The bench aims at the delay-slot split, where a design that mixed up the two cases would write register 17 with a meaningless address or fail to capture the branch target. It re-raises exceptions and interrupts after the first one has been taken, so a unit that ignored the enable or in-progress bits would vector twice and overwrite the saved status. It fires all requests together and then with the exception refused, which exposes a wrong ranking or a refused exception still blocking the break beneath it.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;
  // Vector addresses
  localparam logic [31:0] VEC_USR = 32'h0000_0008;
  localparam logic [31:0] VEC_IRQ = 32'h0000_0010;
  localparam logic [31:0] VEC_BRK = 32'h0000_0018;
  localparam logic [31:0] VEC_EXC = 32'h0000_0020;

  // Status register bit positions
  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EE  = 8;
  localparam int MSR_EIP = 9;
  localparam int ESR_DS  = 12;

  // Dedicated link registers
  localparam int LINK_EXC = 17;
  localparam int LINK_BRK = 16;
  localparam int LINK_IRQ = 14;

  typedef struct packed {
    logic takeExc;
    logic takeBrk;
    logic takeIrq;
    logic takeUsr;
  } trapStrobe_t;
endpackage

// File: rtl/trap_vec_ctrl.sv
module trap_vec_ctrl
  import trap_vec_pkg::*;
(
  input  logic        excReq,
  input  logic        brkReq,
  input  logic        irqReq,
  input  logic        usrReq,
  input  logic        msrEe,
  input  logic        msrIe,
  input  logic        msrBip,
  input  logic        msrEip,
  output trapStrobe_t stb
);
  logic excOk;
  logic irqOk;

  assign excOk = excReq && msrEe;
  assign irqOk = irqReq && msrIe && !msrBip && !msrEip;

  // Fixed ranking: exception, break, interrupt, user trap
  always_comb begin
    stb = '0;
    if (excOk)       stb.takeExc = 1'b1;
    else if (brkReq) stb.takeBrk = 1'b1;
    else if (irqOk)  stb.takeIrq = 1'b1;
    else if (usrReq) stb.takeUsr = 1'b1;
  end
endmodule

// File: rtl/trap_vec_datapath.sv
module trap_vec_datapath
  import trap_vec_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          RIDX_W    = 5,
  parameter int          CAUSE_W   = 5,
  parameter logic [31:0] RESET_MSR = 32'h0000_0102
) (
  input  logic               clk,
  input  logic               rstN,
  input  trapStrobe_t        stb,
  input  logic [XLEN-1:0]    nextPc,
  input  logic [XLEN-1:0]    curPc,
  input  logic               inDelaySlot,
  input  logic [XLEN-1:0]    branchTarget,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [XLEN-1:0]    excAddr,
  input  logic [XLEN-1:0]    excFsr,
  input  logic [RIDX_W-1:0]  usrReg,
  output logic [XLEN-1:0]    pcQ,
  output logic [XLEN-1:0]    msrQ,
  output logic [XLEN-1:0]    esrQ,
  output logic [XLEN-1:0]    earQ,
  output logic [XLEN-1:0]    fsrQ,
  output logic [XLEN-1:0]    btrQ,
  output logic               rfWeQ,
  output logic [RIDX_W-1:0]  rfAddrQ,
  output logic [XLEN-1:0]    rfDataQ
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ     <= '0;
      msrQ    <= XLEN'(RESET_MSR);
      esrQ    <= '0;
      earQ    <= '0;
      fsrQ    <= '0;
      btrQ    <= '0;
      rfWeQ   <= 1'b0;
      rfAddrQ <= '0;
      rfDataQ <= '0;
    end else begin
      rfWeQ <= 1'b0;
      pcQ   <= nextPc;
      if (stb.takeExc) begin
        pcQ                   <= XLEN'(VEC_EXC);
        msrQ[MSR_EE]          <= 1'b0;
        msrQ[MSR_EIP]         <= 1'b1;
        esrQ                  <= '0;
        esrQ[CAUSE_W-1:0]     <= excCause;
        esrQ[ESR_DS]          <= inDelaySlot;
        earQ                  <= excAddr;
        fsrQ                  <= excFsr;
        if (inDelaySlot) begin
          btrQ <= branchTarget;
        end else begin
          rfWeQ   <= 1'b1;
          rfAddrQ <= RIDX_W'(LINK_EXC);
          rfDataQ <= curPc + INSN_BYTES;
        end
      end else if (stb.takeBrk) begin
        pcQ           <= XLEN'(VEC_BRK);
        msrQ[MSR_BIP] <= 1'b1;
        rfWeQ         <= 1'b1;
        rfAddrQ       <= RIDX_W'(LINK_BRK);
        rfDataQ       <= curPc;
      end else if (stb.takeIrq) begin
        pcQ          <= XLEN'(VEC_IRQ);
        msrQ[MSR_IE] <= 1'b0;
        rfWeQ        <= 1'b1;
        rfAddrQ      <= RIDX_W'(LINK_IRQ);
        rfDataQ      <= curPc;
      end else if (stb.takeUsr) begin
        pcQ     <= XLEN'(VEC_USR);
        rfWeQ   <= 1'b1;
        rfAddrQ <= usrReg;
        rfDataQ <= curPc;
      end
    end
  end

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R2
  exc_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeExc |=> (pcQ == XLEN'(VEC_EXC)) && !msrQ[MSR_EE] && msrQ[MSR_EIP]);

  // R4
  exc_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeExc && inDelaySlot) |=> esrQ[ESR_DS] && !rfWeQ);

  // R7
  brk_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeBrk |=> rfWeQ && (rfAddrQ == RIDX_W'(LINK_BRK)) && msrQ[MSR_BIP]);

  // R8
  irq_ie_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeIrq |=> !msrQ[MSR_IE] && (pcQ == XLEN'(VEC_IRQ)));

  // R12
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb == '0) |=> !rfWeQ);
endmodule

// File: rtl/trap_vector_unit.sv
module trap_vector_unit
  import trap_vec_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          RIDX_W    = 5,
  parameter int          CAUSE_W   = 5,
  parameter logic [31:0] RESET_MSR = 32'h0000_0102
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [XLEN-1:0]    nextPc,
  input  logic [XLEN-1:0]    curPc,
  input  logic               inDelaySlot,
  input  logic [XLEN-1:0]    branchTarget,
  input  logic               excReq,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [XLEN-1:0]    excAddr,
  input  logic [XLEN-1:0]    excFsr,
  input  logic               brkReq,
  input  logic               irqReq,
  input  logic               usrReq,
  input  logic [RIDX_W-1:0]  usrReg,
  output logic [XLEN-1:0]    pc,
  output logic [XLEN-1:0]    msr,
  output logic [XLEN-1:0]    esr,
  output logic [XLEN-1:0]    ear,
  output logic [XLEN-1:0]    fsr,
  output logic [XLEN-1:0]    btr,
  output logic               rfWe,
  output logic [RIDX_W-1:0]  rfAddr,
  output logic [XLEN-1:0]    rfData
);
  trapStrobe_t stb;

  trap_vec_ctrl u_ctrl (
    .excReq (excReq),
    .brkReq (brkReq),
    .irqReq (irqReq),
    .usrReq (usrReq),
    .msrEe  (msr[MSR_EE]),
    .msrIe  (msr[MSR_IE]),
    .msrBip (msr[MSR_BIP]),
    .msrEip (msr[MSR_EIP]),
    .stb    (stb)
  );

  trap_vec_datapath #(
    .XLEN      (XLEN),
    .RIDX_W    (RIDX_W),
    .CAUSE_W   (CAUSE_W),
    .RESET_MSR (RESET_MSR)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .nextPc       (nextPc),
    .curPc        (curPc),
    .inDelaySlot  (inDelaySlot),
    .branchTarget (branchTarget),
    .excCause     (excCause),
    .excAddr      (excAddr),
    .excFsr       (excFsr),
    .usrReg       (usrReg),
    .pcQ          (pc),
    .msrQ         (msr),
    .esrQ         (esr),
    .earQ         (ear),
    .fsrQ         (fsr),
    .btrQ         (btr),
    .rfWeQ        (rfWe),
    .rfAddrQ      (rfAddr),
    .rfDataQ      (rfData)
  );
endmodule

// File: tb/test_trap_vector_unit.sv
`timescale 1ns/1ps
module test_trap_vector_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] nextPc = '0, curPc = '0, branchTarget = '0;
  logic        inDelaySlot = 1'b0;
  logic        excReq = 1'b0, brkReq = 1'b0, irqReq = 1'b0, usrReq = 1'b0;
  logic [4:0]  excCause = '0, usrReg = '0;
  logic [31:0] excAddr = '0, excFsr = '0;
  logic [31:0] pc, msr, esr, ear, fsr, btr, rfData;
  logic        rfWe;
  logic [4:0]  rfAddr;
  int          nRun = 0, nFail = 0;

  always #2.5 clk = ~clk;

  trap_vector_unit i_trap_vector_unit (
    .clk(clk), .rstN(rstN), .nextPc(nextPc), .curPc(curPc),
    .inDelaySlot(inDelaySlot), .branchTarget(branchTarget),
    .excReq(excReq), .excCause(excCause), .excAddr(excAddr), .excFsr(excFsr),
    .brkReq(brkReq), .irqReq(irqReq), .usrReq(usrReq), .usrReg(usrReg),
    .pc(pc), .msr(msr), .esr(esr), .ear(ear), .fsr(fsr), .btr(btr),
    .rfWe(rfWe), .rfAddr(rfAddr), .rfData(rfData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearReq();
    excReq = 0; brkReq = 0; irqReq = 0; usrReq = 0; inDelaySlot = 0;
  endtask

  task automatic doReset();
    clearReq();
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
  endtask

  // advance one edge and sample 1 ns later
  task automatic tick();
    @(posedge clk);
    #1;
    clearReq();
  endtask

  task automatic testReset();
    doReset();
    chk("R1 pc", pc, 32'h0);
    chk("R1 msr", msr, 32'h102);
    chk("R1 esr/ear/fsr/btr", esr | ear | fsr | btr, 32'h0);
    chk("R1 rfWe", 32'(rfWe), 32'h0);
  endtask

  task automatic testIdle();
    doReset();
    nextPc = 32'h100;
    tick();
    chk("R12 pc", pc, 32'h100);
    chk("R12 rfWe", 32'(rfWe), 32'h0);
  endtask

  task automatic testExcNoSlot();
    doReset();
    curPc = 32'h1000; nextPc = 32'h1004; branchTarget = 32'h2222;
    excCause = 5'h0B; excAddr = 32'hDEAD_0000; excFsr = 32'h5; excReq = 1;
    tick();
    chk("R2 pc", pc, 32'h20);
    chk("R2 msr", msr, 32'h202);
    chk("R3 rf write", {rfWe, 26'(0), rfAddr}, {1'b1, 26'(0), 5'd17});
    chk("R3 rfData", rfData, 32'h1004);
    chk("R3 btr", btr, 32'h0);
    chk("R5 esr", esr, 32'h0B);
    chk("R5 ear", ear, 32'hDEAD_0000);
    chk("R5 fsr", fsr, 32'h5);
    // second exception while enable is clear
    nextPc = 32'h24; excCause = 5'h03; excAddr = 32'h1; excFsr = 32'h9; excReq = 1;
    tick();
    chk("R6 pc", pc, 32'h24);
    chk("R6 esr", esr, 32'h0B);
    chk("R6 ear", ear, 32'hDEAD_0000);
    chk("R6 fsr", fsr, 32'h5);
    chk("R6 msr", msr, 32'h202);
    // interrupt while exception in progress
    nextPc = 32'h28; irqReq = 1;
    tick();
    chk("R9 eip pc", pc, 32'h28);
    chk("R9 eip rfWe", 32'(rfWe), 32'h0);
  endtask

  task automatic testExcSlot();
    doReset();
    curPc = 32'h1100; nextPc = 32'h1104; branchTarget = 32'h3000;
    excCause = 5'h02; excReq = 1; inDelaySlot = 1;
    tick();
    chk("R4 esr", esr, 32'h1002);
    chk("R4 btr", btr, 32'h3000);
    chk("R4 rfWe", 32'(rfWe), 32'h0);
  endtask

  task automatic testBreak();
    doReset();
    curPc = 32'h400; nextPc = 32'h404; brkReq = 1;
    tick();
    chk("R7 pc", pc, 32'h18);
    chk("R7 msr", msr, 32'h10A);
    chk("R7 rf", {rfWe, 26'(0), rfAddr}, {1'b1, 26'(0), 5'd16});
    chk("R7 rfData", rfData, 32'h400);
    nextPc = 32'h1C; irqReq = 1;
    tick();
    chk("R9 bip pc", pc, 32'h1C);
    chk("R9 bip rfWe", 32'(rfWe), 32'h0);
  endtask

  task automatic testIrq();
    doReset();
    curPc = 32'h500; nextPc = 32'h504; irqReq = 1;
    tick();
    chk("R8 pc", pc, 32'h10);
    chk("R8 msr", msr, 32'h100);
    chk("R8 rf", {rfWe, 26'(0), rfAddr}, {1'b1, 26'(0), 5'd14});
    chk("R8 rfData", rfData, 32'h500);
    nextPc = 32'h14; irqReq = 1;
    tick();
    chk("R9 ie pc", pc, 32'h14);
    chk("R9 ie rfWe", 32'(rfWe), 32'h0);
  endtask

  task automatic testUsr();
    doReset();
    curPc = 32'h600; nextPc = 32'h604; usrReg = 5'd15; usrReq = 1;
    tick();
    chk("R10 pc", pc, 32'h8);
    chk("R10 rf", {rfWe, 26'(0), rfAddr}, {1'b1, 26'(0), 5'd15});
    chk("R10 rfData", rfData, 32'h600);
    chk("R10 msr", msr, 32'h102);
  endtask

  task automatic testPriority();
    doReset();
    curPc = 32'h700; nextPc = 32'h704; usrReg = 5'd3;
    excReq = 1; brkReq = 1; irqReq = 1; usrReq = 1;
    tick();
    chk("R11 all pc", pc, 32'h20);
    chk("R11 all addr", 32'(rfAddr), 32'd17);
    // exception now refused: break must win
    excReq = 1; brkReq = 1; irqReq = 1; usrReq = 1;
    tick();
    chk("R11 refused exc pc", pc, 32'h18);
    chk("R11 refused exc addr", 32'(rfAddr), 32'd16);
    doReset();
    brkReq = 1; irqReq = 1; usrReq = 1;
    tick();
    chk("R11 brk>irq pc", pc, 32'h18);
    doReset();
    irqReq = 1; usrReq = 1;
    tick();
    chk("R11 irq>usr pc", pc, 32'h10);
    // interrupt now refused: user trap must win
    irqReq = 1; usrReq = 1;
    tick();
    chk("R11 refused irq pc", pc, 32'h8);
    chk("R11 refused irq addr", 32'(rfAddr), 32'd3);
  endtask

  initial begin
    testReset();
    testIdle();
    testExcNoSlot();
    testExcSlot();
    testBreak();
    testIrq();
    testUsr();
    testPriority();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule